// File: doc/BRIEF.md
# Fourth-Order Cascaded Fractional Modulator

This block produces the cycle-by-cycle modulus offset for a fractional-N feedback divider. A 4-bit fraction word sets the average offset in steps of 1/16. Each cycle in which `enable` is high is one reference event. On each such event the block emits one signed offset. The divider adds this offset to its integer ratio, so the average ratio becomes N + frac/16.

The modulator is four first-order accumulator stages in cascade. The first stage integrates the fraction. Every later stage integrates the residue left in the stage before it. The carry bits from the stages meet in a noise-cancellation network, which applies a first difference to the second carry, a second difference to the third and a third difference to the fourth. The carries are summed after that, so the quantization error ends up shaped to fourth order. No dither is injected. The output sequence therefore depends only on the fraction and on the steps taken since reset. The cascade of first-order loops has no stability limit on the input.

Top module: `mash4_frac_mod`

## Requirements
- R1: While reset is asserted (rst_n low), all accumulators and difference registers clear and `offset` reads 0.
- R2: If `frac` is 0 on every enabled cycle since reset, `offset` stays 0.
- R3: `offset` is a 5-bit two's-complement value that always lies between -7 and +8 inclusive.
- R4: A cycle with `enable` low advances nothing. `offset` holds its value, and the sequence later resumes exactly where it stopped, as if the idle cycles had never occurred.
- R5: Each rising clock edge at which `enable` is high performs one modulator step. The result of that step appears on `offset` right after that same edge, so the output has one register of latency.
- R6: Let S be the sum of all offsets produced since reset, and let T be the sum of all fractions sampled on enabled edges. After every step, S minus floor(T/16) lies in [-3, +4]. This holds for a constant fraction and for a fraction that changes from step to step.
- R7: After a reset, the same fraction yields the identical offset sequence again, with no randomization.
- R8: From reset with `frac` = 1, the first five offsets are 0, 0, 0, +2, -4.
- R9: `frac` is sampled only on enabled edges. A value placed on `frac` while `enable` is low has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advance one modulator step on this edge (one reference event) |
| frac | input | 4 | Unsigned fraction; the average offset is frac/16 |
| offset | output | 5 | Signed modulus offset for the divider, range -7..+8 |

## Verification
A corrupted accumulator or difference register does not show up as a single bad value. It shows as a running offset total that drifts away from T/16. The cumulative window of R6 catches such a drift within a few steps, because a correct design can never stray more than a few counts from that total. A wrong stage order or a wrong difference sign breaks the exact opening sequence for fraction 1 within five steps. A step taken on an idle cycle breaks the resumed-sequence comparison and the held-output check on the very next edge.

// File: rtl/mash_pkg.sv
package mash_pkg;
  // Default fraction width and cascade order.
  localparam int FRAC_W_DEF = 4;
  localparam int ORDER_DEF  = 4;

  // An order-L cancellation network spans -(2^(L-1)-1) .. +2^(L-1),
  // which needs L+1 bits in two's complement.
  function automatic int offset_width(input int order);
    return order + 1;
  endfunction
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] residue,
  output logic         carry
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, din};
  end

  // The residue is the post-step accumulator value; the next stage integrates it.
  assign residue = sum[W-1:0];
  assign carry   = sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= sum[W-1:0];
  end
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel #(
  parameter int ORDER = 4,
  parameter int OUT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [ORDER-1:0]        carry,
  output logic signed [OUT_W-1:0] y_next
);
  // Nested form: term(k) = carry(k) + term(k+1) - previous term(k+1).
  // This needs one register per stage above the first.
  logic signed [OUT_W-1:0] term   [1:ORDER];
  logic signed [OUT_W-1:0] term_q [1:ORDER];

  function automatic logic signed [OUT_W-1:0] widen(input logic b);
    return {{(OUT_W-1){1'b0}}, b};
  endfunction

  always_comb begin
    term[ORDER] = widen(carry[ORDER-1]);
    for (int k = ORDER-1; k >= 1; k--) begin
      term[k] = widen(carry[k-1]) + term[k+1] - term_q[k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= ORDER; k++) term_q[k] <= '0;
    end else if (step) begin
      for (int k = 1; k <= ORDER; k++) term_q[k] <= term[k];
    end
  end

  assign y_next = term[1];
endmodule

// File: rtl/mash4_frac_mod.sv
module mash4_frac_mod
  import mash_pkg::*;
#(
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int ORDER  = ORDER_DEF,
  localparam int OUT_W = offset_width(ORDER)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [FRAC_W-1:0]       frac,
  output logic signed [OUT_W-1:0] offset
);
  logic [FRAC_W-1:0]       chain [0:ORDER];
  logic [ORDER-1:0]        carries;
  logic signed [OUT_W-1:0] y_next;

  assign chain[0] = frac;

  generate
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
      mash_acc_stage #(.W(FRAC_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (enable),
        .din     (chain[g]),
        .residue (chain[g+1]),
        .carry   (carries[g])
      );
    end
  endgenerate

  mash_noise_cancel #(.ORDER(ORDER), .OUT_W(OUT_W)) u_cancel (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (enable),
    .carry  (carries),
    .y_next (y_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset <= '0;
    else if (enable) offset <= y_next;
  end
endmodule

// File: rtl/mash4_frac_mod_chk.sv
module mash4_frac_mod_chk #(
  parameter int FRAC_W = 4,
  parameter int ORDER  = 4,
  localparam int OUT_W = ORDER + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic [FRAC_W-1:0]       frac,
  input logic signed [OUT_W-1:0] offset
);
  localparam int HI = 2 ** (ORDER - 1);
  localparam int LO = -(HI - 1);

  int   ysum_q, total_q, ysum_now, drift;
  logic step_done_q, nonzero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ysum_q      <= 0;
      total_q     <= 0;
      step_done_q <= 1'b0;
      nonzero_q   <= 1'b0;
    end else begin
      step_done_q <= enable;
      if (step_done_q) ysum_q <= ysum_q + int'(offset);
      if (enable) begin
        total_q <= total_q + int'(frac);
        if (frac != '0) nonzero_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ysum_now = ysum_q + (step_done_q ? int'(offset) : 0);
    drift    = ysum_now - (total_q >>> FRAC_W);
  end

  // R3
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) >= LO) && (int'(offset) <= HI));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(offset));

  // R2
  zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nonzero_q |-> (offset == '0));

  // R6
  cumulative_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drift >= -3) && (drift <= 4));
endmodule

bind mash4_frac_mod mash4_frac_mod_chk #(.FRAC_W(FRAC_W), .ORDER(ORDER)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .frac   (frac),
  .offset (offset)
);

// File: tb/test_mash4_frac_mod.sv
module test_mash4_frac_mod;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [3:0]        frac = '0;
  logic signed [4:0] offset;

  int checks = 0;
  int failures = 0;
  int ysum = 0;
  int total = 0;
  bit finished = 0;

  mash4_frac_mod i_mash4_frac_mod (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frac(frac), .offset(offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; frac = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ysum = 0; total = 0;
  endtask

  task automatic step(input logic [3:0] f, output int y);
    enable = 1'b1; frac = f;
    @(negedge clk);
    enable = 1'b0;
    y = int'(offset);
    ysum += y;
    total += int'(f);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; frac = 4'd9;
    repeat (3) @(negedge clk);
    check(offset == 0, "R1 offset during reset", int'(offset), 0);
    enable = 1'b0;
    do_reset();
    check(offset == 0, "R1 offset after reset", int'(offset), 0);
  endtask

  task automatic t_zero();
    int y;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      step(4'd0, y);
      check(y == 0, "R2 zero fraction", y, 0);
    end
  endtask

  task automatic t_known();
    int exp_seq [5] = '{0, 0, 0, 2, -4};
    int y;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      step(4'd1, y);
      check(y == exp_seq[i], "R8 R5 opening sequence frac=1", y, exp_seq[i]);
    end
  endtask

  task automatic run_bounds(input logic [3:0] f, input int n, input bit vary);
    int y, d;
    logic [3:0] cur;
    do_reset();
    for (int i = 0; i < n; i++) begin
      cur = vary ? 4'((i * 5 + 3) % 16) : f;
      step(cur, y);
      check(y >= -7 && y <= 8, "R3 offset range", y, 0);
      d = ysum - (total >>> 4);
      check(d >= -3 && d <= 4, "R6 cumulative tracking", d, 0);
    end
  endtask

  task automatic t_hold();
    int refv [30];
    int y;
    do_reset();
    for (int i = 0; i < 30; i++) step(4'd3, refv[i]);
    do_reset();
    for (int i = 0; i < 10; i++) step(4'd3, y);
    frac = 4'd9;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(int'(offset) == refv[9], "R4 R9 output held while idle", int'(offset), refv[9]);
    end
    for (int i = 10; i < 30; i++) begin
      step(4'd3, y);
      check(y == refv[i], "R4 R9 resumed sequence", y, refv[i]);
    end
  endtask

  task automatic t_repeat();
    int first [64];
    int y;
    do_reset();
    for (int i = 0; i < 64; i++) step(4'd11, first[i]);
    do_reset();
    for (int i = 0; i < 64; i++) begin
      step(4'd11, y);
      check(y == first[i], "R7 repeatable after reset", y, first[i]);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_known();
    run_bounds(4'd1, 200, 0);
    run_bounds(4'd7, 200, 0);
    run_bounds(4'd8, 200, 0);
    run_bounds(4'd15, 200, 0);
    run_bounds(4'd5, 200, 0);
    run_bounds(4'd0, 300, 1);
    t_hold();
    t_repeat();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule